// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a short burst to a synchronous memory. When a new access starts, the block takes the full external address. The upper bits stay in place for the rest of the burst. The two low bits become the seed offset. Each later advance moves the low bits to the next beat offset, and the upper bits do not change.

The order of the beats is set by a mode input that stays fixed during operation. In interleaved order, each beat offset is the seed XOR-ed with a beat count. In linear order, it is the seed plus the beat count, modulo the burst length. Both orders may start from any seed. After the last beat the sequence wraps back to the seed and keeps cycling while advances continue. A clock-enable input freezes the whole block, so a stalled cycle stretches the current beat.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held, and in the cycle after it releases, the address output is all zeros.
- R2: On a rising edge with clkEn=1 and loadStb=1, the output takes the value of extAddr from that edge, one cycle later, and the beat count restarts at zero.
- R3: With seqInterleave=1, the low two output bits after k advances since a load equal seed XOR k. For example, seed 01 gives 01, 00, 11, 10.
- R4: With seqInterleave=0, the low two output bits after k advances equal (seed + k) mod 4. For example, seed 10 gives 10, 11, 00, 01.
- R5: The fourth advance after a load brings the low bits back to the seed, and the sequence keeps repeating while advances continue.
- R6: An advance never changes the upper output bits (bit 2 and above), even when the low bits wrap from 11 to 00.
- R7: On an edge with clkEn=0, the output and all internal state hold, whatever loadStb, advStb and extAddr are.
- R8: On an enabled edge with loadStb=0 and advStb=0, the output holds.
- R9: When loadStb and advStb are both 1 on an enabled edge, the load wins and the advance is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Clock enable; 0 freezes the block |
| loadStb | input | 1 | Start a new burst from extAddr |
| advStb | input | 1 | Step to the next beat offset |
| seqInterleave | input | 1 | 1 selects XOR order, 0 selects modulo-add order; static |
| extAddr | input | ADDR_W (19) | External start address |
| curAddr | output | ADDR_W (19) | Address of the current beat |

## Verification
The assertions assume that seqInterleave changes only while reset is held, because the order is meant to be static. The stimulus only ever switches the mode between reset pulses. The strobes and the address are driven away from the clock edge. A load that coincides with an advance is treated as a legal combination and is exercised on purpose. Bursts that are cut short by a new load, and advances that continue past the wrap, are both driven in interleaved and in linear order. Upper-bit values that would carry out of the low bits are also driven.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Strobes from the control decode to the address datapath.
  typedef struct packed {
    logic load;   // latch a new start address
    logic step;   // move to the next beat
  } burstStrobes_t;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic          clkEn,
  input  logic          loadStb,
  input  logic          advStb,
  output burstStrobes_t strobes
);

  // A disabled edge does nothing (R7). Load has priority over step (R9).
  always_comb begin
    strobes.load = clkEn & loadStb;
    strobes.step = clkEn & advStb & ~loadStb;
  end

endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstStrobes_t     strobes,
  input  logic              seqInterleave,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] curAddr
);

  localparam int BEAT_W = $clog2(BURST_LEN);

  logic [ADDR_W-1:BEAT_W] upperQ;
  logic [BEAT_W-1:0]      seedQ;
  logic [BEAT_W-1:0]      beatQ;
  logic [BEAT_W-1:0]      xorOffset;
  logic [BEAT_W-1:0]      addOffset;
  logic [BEAT_W-1:0]      beatOffset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperQ <= '0;
      seedQ  <= '0;
      beatQ  <= '0;
    end else if (strobes.load) begin
      upperQ <= extAddr[ADDR_W-1:BEAT_W];
      seedQ  <= extAddr[BEAT_W-1:0];
      beatQ  <= '0;
    end else if (strobes.step) begin
      beatQ  <= beatQ + 1'b1;   // the natural wrap gives the burst wrap
    end
  end

  // Each bit of the interleaved offset flips on its own.
  for (genvar b = 0; b < BEAT_W; b++) begin : g_xorBit
    assign xorOffset[b] = seedQ[b] ^ beatQ[b];
  end

  assign addOffset  = seedQ + beatQ;
  assign beatOffset = seqInterleave ? xorOffset : addOffset;
  assign curAddr    = {upperQ, beatOffset};

  AST_BEAT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (beatQ == '0)); // R2

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> (beatQ == BEAT_W'($past(beatQ) + 1'b1))); // R5

  AST_SEED_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(seedQ)); // R6

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              loadStb,
  input  logic              advStb,
  input  logic              seqInterleave,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] curAddr
);

  localparam int BEAT_W = $clog2(BURST_LEN);

  burstStrobes_t strobes;

  burst_ctrl u_ctrl (
    .clkEn   (clkEn),
    .loadStb (loadStb),
    .advStb  (advStb),
    .strobes (strobes)
  );

  burst_datapath #(
    .ADDR_W    (ADDR_W),
    .BURST_LEN (BURST_LEN)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .seqInterleave (seqInterleave),
    .extAddr       (extAddr),
    .curAddr       (curAddr)
  );

  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && loadStb) |=> (curAddr == $past(extAddr))); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(curAddr)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !loadStb && !advStb) |=> $stable(curAddr)); // R8

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !loadStb && advStb) |=>
      (curAddr[ADDR_W-1:BEAT_W] == $past(curAddr[ADDR_W-1:BEAT_W]))); // R6

endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;

  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          clkEn = 1'b0;
  logic          loadStb = 1'b0;
  logic          advStb = 1'b0;
  logic          seqInterleave = 1'b1;
  logic [AW-1:0] extAddr = '0;
  logic [AW-1:0] curAddr;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;   // 125 MHz

  burst_addr_gen #(.ADDR_W(AW), .BURST_LEN(4)) dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .loadStb(loadStb),
    .advStb(advStb), .seqInterleave(seqInterleave),
    .extAddr(extAddr), .curAddr(curAddr)
  );

  typedef struct packed {
    logic          en;
    logic          ld;
    logic          adv;
    logic [AW-1:0] addr;
    logic [AW-1:0] expAddr;
    logic [3:0]    req;
  } vec_t;

  // Interleaved order (seqInterleave=1).
  localparam vec_t VEC [17] = '{
    '{1'b1, 1'b1, 1'b0, 19'h12345, 19'h12345, 4'd2}, // R2 load, seed 01
    '{1'b1, 1'b0, 1'b1, 19'h00000, 19'h12344, 4'd3}, // R3 01^1=00
    '{1'b1, 1'b0, 1'b1, 19'h00000, 19'h12347, 4'd3}, // R3 01^2=11
    '{1'b1, 1'b0, 1'b1, 19'h00000, 19'h12346, 4'd3}, // R3 01^3=10
    '{1'b1, 1'b0, 1'b1, 19'h00000, 19'h12345, 4'd5}, // R5 wrap to seed
    '{1'b1, 1'b0, 1'b1, 19'h00000, 19'h12344, 4'd5}, // R5 keeps cycling
    '{1'b0, 1'b0, 1'b1, 19'h55555, 19'h12344, 4'd7}, // R7 advance ignored
    '{1'b0, 1'b1, 1'b0, 19'h7FFFF, 19'h12344, 4'd7}, // R7 load ignored
    '{1'b1, 1'b0, 1'b0, 19'h7FFFF, 19'h12344, 4'd8}, // R8 idle holds
    '{1'b1, 1'b0, 1'b1, 19'h00000, 19'h12347, 4'd3}, // R3 beat 2 after stall
    '{1'b1, 1'b1, 1'b1, 19'h7FFFE, 19'h7FFFE, 4'd9}, // R9 load wins
    '{1'b1, 1'b0, 1'b1, 19'h00000, 19'h7FFFF, 4'd3}, // R3 10^1=11
    '{1'b1, 1'b0, 1'b1, 19'h00000, 19'h7FFFC, 4'd6}, // R6 upper kept
    '{1'b1, 1'b0, 1'b1, 19'h00000, 19'h7FFFD, 4'd3}, // R3 10^3=01
    '{1'b1, 1'b0, 1'b1, 19'h00000, 19'h7FFFE, 4'd5}, // R5 wrap
    '{1'b1, 1'b1, 1'b0, 19'h00003, 19'h00003, 4'd2}, // R2 reload mid-burst
    '{1'b1, 1'b0, 1'b1, 19'h00000, 19'h00002, 4'd3}  // R3 11^1=10
  };

  task automatic check(input logic [AW-1:0] expV, input int req, input string what);
    checks++;
    if (curAddr !== expV) begin
      fails++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, curAddr, expV);
    end
  endtask

  task automatic cycle(input logic en, input logic ld, input logic adv,
                       input logic [AW-1:0] addr);
    clkEn = en; loadStb = ld; advStb = adv; extAddr = addr;
    @(posedge clk);
    #2;
  endtask

  task automatic doReset(input logic mode);
    #2;
    rstN = 1'b0;
    seqInterleave = mode;
    clkEn = 1'b0; loadStb = 1'b0; advStb = 1'b0;
    @(posedge clk); #2;
    check('0, 1, "held in reset");            // R1
    rstN = 1'b1;
    @(posedge clk); #2;
    check('0, 1, "after reset release");      // R1
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    doReset(1'b1);
    foreach (VEC[i]) begin
      cycle(VEC[i].en, VEC[i].ld, VEC[i].adv, VEC[i].addr);
      check(VEC[i].expAddr, int'(VEC[i].req), $sformatf("vector %0d", i));
    end

    // Linear order (R4), including wrap (R5) and a carry boundary (R6).
    doReset(1'b0);
    cycle(1'b1, 1'b1, 1'b0, 19'h12346); check(19'h12346, 2, "linear load seed 10");
    cycle(1'b1, 1'b0, 1'b1, '0);        check(19'h12347, 4, "linear 10+1");
    cycle(1'b1, 1'b0, 1'b1, '0);        check(19'h12344, 6, "linear 10+2 no carry up");
    cycle(1'b1, 1'b0, 1'b1, '0);        check(19'h12345, 4, "linear 10+3");
    cycle(1'b1, 1'b0, 1'b1, '0);        check(19'h12346, 5, "linear wrap");
    cycle(1'b0, 1'b1, 1'b1, 19'h0ABCD); check(19'h12346, 7, "linear stall");
    cycle(1'b1, 1'b1, 1'b0, 19'h7FFFF); check(19'h7FFFF, 2, "linear load seed 11");
    cycle(1'b1, 1'b0, 1'b1, '0);        check(19'h7FFFC, 6, "linear 11+1 upper kept");
    cycle(1'b1, 1'b0, 1'b1, '0);        check(19'h7FFFD, 4, "linear 11+2");
    cycle(1'b1, 1'b1, 1'b1, 19'h00001); check(19'h00001, 9, "linear load wins");
    cycle(1'b1, 1'b0, 1'b0, '0);        check(19'h00001, 8, "linear idle");
    cycle(1'b1, 1'b0, 1'b1, '0);        check(19'h00002, 4, "linear 01+1");

    finishRun();
  end

endmodule